// File: doc/BRIEF.md
# Memory Value Synchronization Unit

This block passes memory-resident values from one speculative thread to the thread that follows it. The producer side issues a signal that carries an address and a data word. The unit records the address in a producer-side buffer and stores the address/data pair in a consumer-side forwarding table. If the producer later stores to an address it has already signalled, the unit reports a misspeculation in the same cycle, because the value already sent is now stale.

On the consumer side, every forwarding entry carries a use-forward flag. A consumer load that hits an entry whose flag is set is served the forwarded word in the same cycle. A miss, or a hit on an entry whose flag has been cleared, selects local memory instead. A consumer store to a forwarded address before the consumer has read that address clears the flag. From then on the thread's own value wins. A single epoch clear input, driven on commit or squash, empties both structures in one cycle.

The signal path is a valid/ready stream. A signal transfers on a cycle where `sig_valid` and `sig_ready` are both high. The unit drops `sig_ready` when the signal needs a new entry and no entry is free, or when `epoch_clear` is high. The producer must then hold the signal stable until it is accepted. `sig_stall` flags a refused, pending signal. The producer store, consumer load and consumer store ports are plain single-cycle strobes with no back-pressure.

Top module: `mvs_sync_unit`

## Requirements
- R1: An accepted signal makes its address visible to producer-store matching and its data visible to consumer loads from the next cycle on. A consumer load hitting that entry raises `ld_use_fwd` and returns the data on `ld_data` in the same cycle.
- R2: An accepted signal to an address that is already held overwrites the stored data in place and allocates no new entry. Such a signal is accepted even when every entry is in use.
- R3: A signal to a new address while all `ENTRIES` entries are in use is refused. `sig_ready` is 0 and `sig_stall` is 1, and nothing is recorded, so a consumer load of that address selects local memory.
- R4: `misspec` is 1 in the same cycle as a producer store whose address matches a signalled address, and 0 for any other address.
- R5: A consumer load that misses selects local memory: `ld_local_sel` is 1, `ld_use_fwd` is 0 and `ld_data` reads 0. Whenever `ld_valid` is 1, exactly one of `ld_use_fwd` and `ld_local_sel` is 1.
- R6: A consumer store to a forwarded address that the consumer has not yet loaded clears the entry's use-forward flag. Later loads of that address select local memory.
- R7: Once the consumer has loaded a forwarded address with the flag set, a consumer store to it leaves the flag set, and later loads still return the forwarded data.
- R8: `epoch_clear` empties both structures in one cycle. After a clear cycle, loads select local memory, producer stores raise no `misspec`, and new signals are accepted. The same empty state holds after reset.
- R9: Address 0 is handled like any other address for signalling, forwarding and misspeculation.
- R10: Same-cycle ordering works as follows. A load and a consumer store to one address in the same cycle act load-first, so the flag stays set. `epoch_clear` refuses a signal presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| epoch_clear | input | 1 | Commit or squash: empty both structures |
| sig_valid | input | 1 | Producer signal present |
| sig_ready | output | 1 | Signal can be accepted this cycle |
| sig_addr | input | AW | Signalled address |
| sig_data | input | DW | Signalled data word |
| sig_stall | output | 1 | Signal pending but refused |
| pst_valid | input | 1 | Producer store strobe |
| pst_addr | input | AW | Producer store address |
| misspec | output | 1 | Producer store hit a signalled address |
| ld_valid | input | 1 | Consumer load strobe |
| ld_addr | input | AW | Consumer load address |
| ld_use_fwd | output | 1 | Load served from the forwarded value |
| ld_local_sel | output | 1 | Load must be served from local memory |
| ld_data | output | DW | Forwarded data, 0 when not forwarding |
| cst_valid | input | 1 | Consumer store strobe |
| cst_addr | input | AW | Consumer store address |

## Verification
The bench builds the unit with `ENTRIES=4`, `AW=32` and `DW=16`. Four entries let a random address pool of six values, including 0 and all-ones, fill the structures within a few signals. This repeatedly exercises refusal when full, in-place updates while full, and refill after clears. The full 32-bit address width keeps the all-ones and zero extremes in play for the associative match. A 16-bit data width still separates every forwarded word the bench writes.

// File: rtl/mvs_pkg.sv
package mvs_pkg;
  typedef enum logic {
    SRC_LOCAL = 1'b0,
    SRC_FWD   = 1'b1
  } ld_src_e;
endpackage

// File: rtl/mvs_sig_addr_buf.sv
// Producer-side record of addresses already signalled, with store matching.
module mvs_sig_addr_buf #(
  parameter int ENTRIES = 8,
  parameter int AW      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               sig_we,
  input  logic [AW-1:0]      sig_addr,
  input  logic               st_valid,
  input  logic [AW-1:0]      st_addr,
  output logic               sig_hit,
  output logic               full,
  output logic               misspec,
  output logic [ENTRIES-1:0] vld_o
);
  logic          vld_q  [ENTRIES];
  logic [AW-1:0] addr_q [ENTRIES];
  logic [ENTRIES-1:0] sig_match, st_match, alloc;

  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_ent
      assign sig_match[gi] = vld_q[gi] && (addr_q[gi] == sig_addr);
      assign st_match[gi]  = vld_q[gi] && (addr_q[gi] == st_addr);
      assign vld_o[gi]     = vld_q[gi];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[gi]  <= 1'b0;
          addr_q[gi] <= '0;
        end else if (clear) begin
          vld_q[gi]  <= 1'b0;
        end else if (sig_we && !sig_hit && alloc[gi]) begin
          vld_q[gi]  <= 1'b1;
          addr_q[gi] <= sig_addr;
        end
      end
    end
  endgenerate

  always_comb begin
    logic found;
    found = 1'b0;
    alloc = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!vld_q[i] && !found) begin
        alloc[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign sig_hit = |sig_match;
  assign full    = &vld_o;
  assign misspec = st_valid && (|st_match);
endmodule

// File: rtl/mvs_fwd_table.sv
// Consumer-side forwarded values with per-entry use-forward and read flags.
module mvs_fwd_table
  import mvs_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int AW      = 32,
  parameter int DW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sig_we,
  input  logic [AW-1:0] sig_addr,
  input  logic [DW-1:0] sig_data,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  output logic          sig_hit,
  output logic          full,
  output ld_src_e       ld_src,
  output logic [DW-1:0] ld_data
);
  logic          vld_q  [ENTRIES];
  logic          use_q  [ENTRIES];
  logic          rd_q   [ENTRIES];
  logic [AW-1:0] addr_q [ENTRIES];
  logic [DW-1:0] data_q [ENTRIES];
  logic [ENTRIES-1:0] sig_match, ld_match, st_match, alloc, vld_vec, fwd_hit;

  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_ent
      assign vld_vec[gi]   = vld_q[gi];
      assign sig_match[gi] = vld_q[gi] && (addr_q[gi] == sig_addr);
      assign ld_match[gi]  = ld_valid && vld_q[gi] && (addr_q[gi] == ld_addr);
      assign st_match[gi]  = st_valid && vld_q[gi] && (addr_q[gi] == st_addr);
      assign fwd_hit[gi]   = ld_match[gi] && use_q[gi];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[gi]  <= 1'b0;
          use_q[gi]  <= 1'b0;
          rd_q[gi]   <= 1'b0;
          addr_q[gi] <= '0;
          data_q[gi] <= '0;
        end else if (clear) begin
          vld_q[gi]  <= 1'b0;
          use_q[gi]  <= 1'b0;
          rd_q[gi]   <= 1'b0;
        end else begin
          // load acts before a same-cycle store
          if (fwd_hit[gi]) rd_q[gi] <= 1'b1;
          if (st_match[gi] && !rd_q[gi] && !fwd_hit[gi]) use_q[gi] <= 1'b0;
          if (sig_we && sig_match[gi]) data_q[gi] <= sig_data;
          if (sig_we && !sig_hit && alloc[gi]) begin
            vld_q[gi]  <= 1'b1;
            use_q[gi]  <= 1'b1;
            rd_q[gi]   <= 1'b0;
            addr_q[gi] <= sig_addr;
            data_q[gi] <= sig_data;
          end
        end
      end
    end
  endgenerate

  always_comb begin
    logic found;
    found = 1'b0;
    alloc = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!vld_q[i] && !found) begin
        alloc[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    ld_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fwd_hit[i]) ld_data = ld_data | data_q[i];
    end
  end

  assign sig_hit = |sig_match;
  assign full    = &vld_vec;
  assign ld_src  = (|fwd_hit) ? SRC_FWD : SRC_LOCAL;
endmodule

// File: rtl/mvs_sync_unit.sv
module mvs_sync_unit
  import mvs_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int AW      = 32,
  parameter int DW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          epoch_clear,
  input  logic          sig_valid,
  output logic          sig_ready,
  input  logic [AW-1:0] sig_addr,
  input  logic [DW-1:0] sig_data,
  output logic          sig_stall,
  input  logic          pst_valid,
  input  logic [AW-1:0] pst_addr,
  output logic          misspec,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_use_fwd,
  output logic          ld_local_sel,
  output logic [DW-1:0] ld_data,
  input  logic          cst_valid,
  input  logic [AW-1:0] cst_addr
);
  logic               pbuf_hit, pbuf_full, tab_hit, tab_full, sig_fire;
  logic [ENTRIES-1:0] pbuf_vld;
  logic [DW-1:0]      tab_data;
  ld_src_e            tab_src;

  assign sig_ready = !epoch_clear && (pbuf_hit || !pbuf_full) && (tab_hit || !tab_full);
  assign sig_fire  = sig_valid && sig_ready;
  assign sig_stall = sig_valid && !sig_ready;

  mvs_sig_addr_buf #(.ENTRIES(ENTRIES), .AW(AW)) pbuf_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (epoch_clear),
    .sig_we   (sig_fire),
    .sig_addr (sig_addr),
    .st_valid (pst_valid),
    .st_addr  (pst_addr),
    .sig_hit  (pbuf_hit),
    .full     (pbuf_full),
    .misspec  (misspec),
    .vld_o    (pbuf_vld)
  );

  mvs_fwd_table #(.ENTRIES(ENTRIES), .AW(AW), .DW(DW)) tab_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (epoch_clear),
    .sig_we   (sig_fire),
    .sig_addr (sig_addr),
    .sig_data (sig_data),
    .ld_valid (ld_valid),
    .ld_addr  (ld_addr),
    .st_valid (cst_valid),
    .st_addr  (cst_addr),
    .sig_hit  (tab_hit),
    .full     (tab_full),
    .ld_src   (tab_src),
    .ld_data  (tab_data)
  );

  assign ld_use_fwd   = ld_valid && (tab_src == SRC_FWD);
  assign ld_local_sel = ld_valid && (tab_src == SRC_LOCAL);
  assign ld_data      = ld_use_fwd ? tab_data : '0;
endmodule

// File: rtl/mvs_sync_chk.sv
module mvs_sync_chk #(
  parameter int ENTRIES = 8,
  parameter int AW      = 32,
  parameter int DW      = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               epoch_clear,
  input logic               sig_valid,
  input logic               sig_ready,
  input logic [AW-1:0]      sig_addr,
  input logic               sig_stall,
  input logic               pst_valid,
  input logic [AW-1:0]      pst_addr,
  input logic               misspec,
  input logic               ld_valid,
  input logic               ld_use_fwd,
  input logic               ld_local_sel,
  input logic [DW-1:0]      ld_data,
  input logic [ENTRIES-1:0] pbuf_vld
);
  AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_stall && !epoch_clear) |-> ($countones(pbuf_vld) == ENTRIES)); // R3

  AST_MISSPEC_AFTER_SIGNAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_valid && sig_ready) |=>
      (epoch_clear || !pst_valid || (pst_addr != $past(sig_addr)) || misspec)); // R4

  AST_ONE_ALLOC_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pbuf_vld) <= $countones($past(pbuf_vld)) + 1); // R2

  AST_LOAD_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> ($countones({ld_use_fwd, ld_local_sel}) == 1)); // R5

  AST_LOCAL_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ld_local_sel |-> (ld_data == '0)); // R5

  AST_CLEAR_FORGETS_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(epoch_clear) && ld_valid) |-> !ld_use_fwd); // R8

  AST_CLEAR_FORGETS_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(epoch_clear) |-> !misspec); // R8

  AST_CLEAR_REFUSES_SIGNAL: assert property (@(posedge clk) disable iff (!rst_n)
    (epoch_clear && sig_valid) |-> sig_stall); // R10
endmodule

bind mvs_sync_unit mvs_sync_chk #(.ENTRIES(ENTRIES), .AW(AW), .DW(DW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .epoch_clear  (epoch_clear),
  .sig_valid    (sig_valid),
  .sig_ready    (sig_ready),
  .sig_addr     (sig_addr),
  .sig_stall    (sig_stall),
  .pst_valid    (pst_valid),
  .pst_addr     (pst_addr),
  .misspec      (misspec),
  .ld_valid     (ld_valid),
  .ld_use_fwd   (ld_use_fwd),
  .ld_local_sel (ld_local_sel),
  .ld_data      (ld_data),
  .pbuf_vld     (pbuf_vld)
);

// File: tb/mvs_sync_unit_tb_top.sv
module mvs_sync_unit_tb_top;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic epoch_clear = 1'b0;
  logic sig_valid = 1'b0, pst_valid = 1'b0, ld_valid = 1'b0, cst_valid = 1'b0;
  logic [AW-1:0] sig_addr = '0, pst_addr = '0, ld_addr = '0, cst_addr = '0;
  logic [DW-1:0] sig_data = '0;
  logic sig_ready, sig_stall, misspec, ld_use_fwd, ld_local_sel;
  logic [DW-1:0] ld_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mvs_sync_unit #(.ENTRIES(N), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .epoch_clear(epoch_clear),
    .sig_valid(sig_valid), .sig_ready(sig_ready), .sig_addr(sig_addr),
    .sig_data(sig_data), .sig_stall(sig_stall),
    .pst_valid(pst_valid), .pst_addr(pst_addr), .misspec(misspec),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_use_fwd(ld_use_fwd),
    .ld_local_sel(ld_local_sel), .ld_data(ld_data),
    .cst_valid(cst_valid), .cst_addr(cst_addr)
  );

  // reference model of the held entries
  bit            m_vld  [N];
  bit            m_use  [N];
  bit            m_rd   [N];
  logic [AW-1:0] m_addr [N];
  logic [DW-1:0] m_data [N];

  function automatic int find(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_addr[i] == a) return i;
    return -1;
  endfunction

  function automatic int used();
    int c = 0;
    for (int i = 0; i < N; i++) if (m_vld[i]) c++;
    return c;
  endfunction

  task automatic chk(string ctx, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", ctx, what, act, exp);
    end
  endtask

  task automatic cyc(string ctx, bit clr,
                     bit sv, logic [AW-1:0] sa, logic [DW-1:0] sd,
                     bit pv, logic [AW-1:0] pa,
                     bit lv, logic [AW-1:0] la,
                     bit cv, logic [AW-1:0] ca);
    bit e_rdy, e_fwd;
    int li, ci, si;
    logic [DW-1:0] e_dat;
    @(negedge clk);
    epoch_clear = clr;
    sig_valid = sv; sig_addr = sa; sig_data = sd;
    pst_valid = pv; pst_addr = pa;
    ld_valid = lv;  ld_addr = la;
    cst_valid = cv; cst_addr = ca;
    #2;
    li    = find(la);
    e_rdy = !clr && (find(sa) >= 0 || used() < N);
    e_fwd = lv && li >= 0 && m_use[li];
    e_dat = e_fwd ? m_data[li] : '0;
    chk(ctx, "R3 sig_ready", 32'(sig_ready), 32'(e_rdy));
    chk(ctx, "R3 sig_stall", 32'(sig_stall), 32'(sv && !e_rdy));
    chk(ctx, "R4 misspec", 32'(misspec), 32'(pv && find(pa) >= 0));
    chk(ctx, "R5 ld_use_fwd", 32'(ld_use_fwd), 32'(e_fwd));
    chk(ctx, "R5 ld_local_sel", 32'(ld_local_sel), 32'(lv && !e_fwd));
    chk(ctx, "R1 ld_data", 32'(ld_data), 32'(e_dat));
    @(posedge clk);
    if (clr) begin
      for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    end else begin
      if (e_fwd) m_rd[li] = 1'b1;
      ci = find(ca);
      if (cv && ci >= 0 && !m_rd[ci]) m_use[ci] = 1'b0;
      if (sv && e_rdy) begin
        si = find(sa);
        if (si >= 0) m_data[si] = sd;
        else begin
          for (int i = 0; i < N; i++) begin
            if (!m_vld[i]) begin
              m_vld[i] = 1'b1; m_use[i] = 1'b1; m_rd[i] = 1'b0;
              m_addr[i] = sa; m_data[i] = sd;
              break;
            end
          end
        end
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pool [6];
    pool[0] = 32'h0; pool[1] = 32'h4; pool[2] = 32'h8;
    pool[3] = 32'h10; pool[4] = 32'h80; pool[5] = 32'hFFFF_FFFF;
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;

    // R8 reset state: empty, load selects local
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = 32'h0;
    #1;
    chk("R8 reset", "ld_local_sel", 32'(ld_local_sel), 32'd1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    cyc("R8 idle", 0, 0,0,0, 0,0, 1,32'h100, 0,0);
    // R1 forward
    cyc("R1 signal", 0, 1,32'h100,16'h1234, 0,0, 0,0, 0,0);
    cyc("R1 load", 0, 0,0,0, 0,0, 1,32'h100, 0,0);
    // R9 address zero
    cyc("R9 signal zero", 0, 1,32'h0,16'hBEEF, 0,0, 0,0, 0,0);
    cyc("R9 load zero", 0, 0,0,0, 1,32'h0, 1,32'h0, 0,0);
    // R4 store matching
    cyc("R4 hit", 0, 0,0,0, 1,32'h100, 0,0, 0,0);
    cyc("R4 miss", 0, 0,0,0, 1,32'h104, 0,0, 0,0);
    // R6 write before read
    cyc("R6 signal", 0, 1,32'h200,16'h2222, 0,0, 0,0, 0,0);
    cyc("R6 store", 0, 0,0,0, 0,0, 0,0, 1,32'h200);
    cyc("R6 load", 0, 0,0,0, 0,0, 1,32'h200, 0,0);
    // R7 write after read
    cyc("R7 signal", 0, 1,32'h300,16'h3333, 0,0, 0,0, 0,0);
    cyc("R7 first load", 0, 0,0,0, 0,0, 1,32'h300, 0,0);
    cyc("R7 store", 0, 0,0,0, 0,0, 0,0, 1,32'h300);
    cyc("R7 second load", 0, 0,0,0, 0,0, 1,32'h300, 0,0);
    // R3 full refusal
    cyc("R3 refuse", 0, 1,32'h400,16'h4444, 0,0, 0,0, 0,0);
    cyc("R3 not recorded", 0, 0,0,0, 1,32'h400, 1,32'h400, 0,0);
    // R2 in-place update while full
    cyc("R2 repeat", 0, 1,32'h100,16'h5555, 0,0, 0,0, 0,0);
    cyc("R2 updated", 0, 0,0,0, 0,0, 1,32'h100, 0,0);
    // R10 clear beats signal; R8 clear empties
    cyc("R10 clear with signal", 1, 1,32'h500,16'h6666, 0,0, 0,0, 0,0);
    cyc("R8 after clear", 0, 0,0,0, 1,32'h100, 1,32'h500, 0,0);
    cyc("R8 refill", 0, 1,32'h600,16'h7777, 0,0, 1,32'h100, 0,0);
    // R10 same-cycle load and store
    cyc("R10 load+store", 0, 0,0,0, 0,0, 1,32'h600, 1,32'h600);
    cyc("R10 still fwd", 0, 0,0,0, 0,0, 1,32'h600, 0,0);

    // constrained random mix
    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      cyc("R1 random", ($urandom % 50) == 0,
          ($urandom % 3) == 0, pool[$urandom % 6], 16'($urandom),
          ($urandom % 4) == 0, pool[$urandom % 6],
          ($urandom % 2) == 0, pool[$urandom % 6],
          ($urandom % 4) == 0, pool[$urandom % 6]);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule